// File: doc/BRIEF.md
# Composite Clock Divider Cell

This cell builds one derived clock from a set of candidate sources. A two-level source choice first takes either the dedicated primary clock or one of up to eight secondary clocks. The selected source then runs through a ratio stage that divides by 1, 2, 3, 4, 6, 8 or 12, and a final enable gate drives the output clock.

The ratio comes from three control bits. A dominant divide-by-3 switch wins over everything else. Otherwise a divider switch either bypasses division (ratio 1) or applies a 3-bit code looked up in a fixed table. The source is set by writing a source index on the configuration clock. Index 0 means the primary clock and index k means secondary clock k-1. Two status outputs report the ratio and the source index currently in effect, so software or a bench can predict the output period. Parameters can remove the source choice or the gate from the cell.

Top module: `composite_clk_div`

## Requirements
- R1: With the divide-by-3 switch clear and the divider switch set, divider code 0,1,2,3,4,5 gives ratio 1,2,4,6,8,12, and codes 6 and 7 give ratio 1.
- R2: With the divide-by-3 switch set, the ratio is 3 whatever the divider switch and code hold.
- R3: With both switches clear, the ratio is 1 and the divider code has no effect.
- R4: The output period equals the reported ratio times the period of the selected source, where index 0 selects the primary clock and index k (1..NSEC) selects secondary clock k-1.
- R5: A source write of index k>0 makes the reported index k on the configuration edge that takes the write; a write of index 0 makes the reported index 0.
- R6: For even ratios the output is high for half its period; for ratio 3 it is high for 1.5 source periods; for ratio 1 the output follows the source waveform.
- R7: With the enable clear the output stays low once its current high phase ends; setting the enable again restores the divided clock.
- R8: With the source choice omitted (HAS_MUX=0) the cell runs from the primary clock and reports index 0 whatever is written; with the gate omitted (HAS_GATE=0) the enable has no effect.
- R9: While reset is asserted the reported ratio is 1 and the reported index is 0.
- R10: A changed ratio takes effect only at the end of the output period in progress; the reported ratio changes only there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary source clock (index 0) |
| clk_sec | input | NSEC | Secondary source clocks (index 1..NSEC) |
| cfg_clk | input | 1 | Configuration clock for the source index register |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_we | input | 1 | Source index write strobe |
| src_idx | input | IDX_W | Source index to write |
| div3_sw | input | 1 | Divide-by-3 switch, dominant |
| div_sw | input | 1 | Divider switch, clear to bypass division |
| div_sel | input | 3 | Divider code for the ratio table |
| gate_en | input | 1 | Output enable |
| clk_o | output | 1 | Divided, gated output clock |
| ratio_o | output | 4 | Ratio in effect |
| src_idx_o | output | IDX_W | Source index in effect |

## Verification
The assertions assume the ratio controls are stable around the rising edges of the selected source and that the source index write is stable around the configuration edge; the bench changes every control at integer nanoseconds, half a primary period away from its rising edge, while the secondary clocks are offset by a quarter nanosecond so none of their edges meets a control change. They also assume written indexes never exceed NSEC, and the bench writes only 0 to 8. Output periods are measured only after several output edges have passed since the last change, so the unprotected source switch may glitch without disturbing any measurement.

// File: rtl/ccd_pkg.sv
`timescale 1ns/1ps
package ccd_pkg;
  localparam int RATIO_W = 4;
  typedef logic [RATIO_W-1:0] ratio_t;

  // table lookup for the programmable stage
  function automatic ratio_t code_to_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return ratio_t'(1);
      3'd1:    return ratio_t'(2);
      3'd2:    return ratio_t'(4);
      3'd3:    return ratio_t'(6);
      3'd4:    return ratio_t'(8);
      3'd5:    return ratio_t'(12);
      default: return ratio_t'(1);
    endcase
  endfunction

  // divide-by-3 dominates, then the bypass, then the table
  function automatic ratio_t pick_ratio(input logic d3, input logic dsw, input logic [2:0] code);
    if (d3)   return ratio_t'(3);
    if (!dsw) return ratio_t'(1);
    return code_to_ratio(code);
  endfunction
endpackage

// File: rtl/ccd_src_sel.sv
`timescale 1ns/1ps
module ccd_src_sel #(
  parameter int NSEC    = 8,
  parameter bit HAS_MUX = 1'b1,
  localparam int SEL_W  = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int IDX_W  = SEL_W + 1
) (
  input  logic             cfg_clk,
  input  logic             rst_n,
  input  logic             src_we,
  input  logic [IDX_W-1:0] src_idx,
  input  logic             clk_pri,
  input  logic [NSEC-1:0]  clk_sec,
  output logic             clk_src,
  output logic [IDX_W-1:0] idx_o
);
  logic             byp_q;
  logic [SEL_W-1:0] sel_q;

  // index 0 clears the bypass and keeps the select field
  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      sel_q <= '0;
    end else if (src_we) begin
      if (src_idx == '0) begin
        byp_q <= 1'b0;
      end else begin
        byp_q <= 1'b1;
        sel_q <= SEL_W'(src_idx - IDX_W'(1));
      end
    end
  end

  generate
    if (HAS_MUX) begin : g_mux
      assign clk_src = byp_q ? clk_sec[sel_q] : clk_pri;
      assign idx_o   = byp_q ? (IDX_W'(sel_q) + IDX_W'(1)) : '0;
    end else begin : g_nomux
      logic unused_sel;
      assign unused_sel = ^{byp_q, sel_q, clk_sec};
      assign clk_src    = clk_pri;
      assign idx_o      = '0;
    end
  endgenerate
endmodule

// File: rtl/ccd_divider.sv
`timescale 1ns/1ps
module ccd_divider
  import ccd_pkg::*;
(
  input  logic   clk_src,
  input  logic   rst_n,
  input  ratio_t req_ratio,
  output logic   clk_div,
  output ratio_t act_ratio,
  output logic   wrap
);
  ratio_t cnt_q, cnt_n, act_q, act_n;
  logic   pos_q;   // high half for even ratios
  logic   ph_a_q;  // rising-edge phase for ratio 3
  logic   ph_b_q;  // falling-edge copy of ph_a_q

  assign wrap  = (cnt_q == act_q - ratio_t'(1));
  assign cnt_n = wrap ? '0 : cnt_q + ratio_t'(1);
  assign act_n = wrap ? req_ratio : act_q;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= ratio_t'(1);
      pos_q  <= 1'b0;
      ph_a_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      pos_q  <= (cnt_n < (act_n >> 1));
      ph_a_q <= (cnt_n == '0);
    end
  end

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) ph_b_q <= 1'b0;
    else        ph_b_q <= ph_a_q;
  end

  always_comb begin
    if (act_q == ratio_t'(1))      clk_div = clk_src;
    else if (act_q == ratio_t'(3)) clk_div = ph_a_q | ph_b_q;
    else                           clk_div = pos_q;
  end

  assign act_ratio = act_q;
endmodule

// File: rtl/ccd_gate.sv
`timescale 1ns/1ps
module ccd_gate #(
  parameter bit HAS_GATE = 1'b1
) (
  input  logic clk_in,
  input  logic en,
  output logic clk_out
);
  generate
    if (HAS_GATE) begin : g_gate
      logic en_l;
      // enable passes only while the clock is low
      always_latch begin
        if (!clk_in) en_l = en;
      end
      assign clk_out = clk_in & en_l;
    end else begin : g_open
      logic unused_en;
      assign unused_en = en;
      assign clk_out   = clk_in;
    end
  endgenerate
endmodule

// File: rtl/composite_clk_div.sv
`timescale 1ns/1ps
module composite_clk_div
  import ccd_pkg::*;
#(
  parameter int NSEC     = 8,
  parameter bit HAS_MUX  = 1'b1,
  parameter bit HAS_GATE = 1'b1,
  localparam int SEL_W   = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int IDX_W   = SEL_W + 1
) (
  input  logic               clk_pri,
  input  logic [NSEC-1:0]    clk_sec,
  input  logic               cfg_clk,
  input  logic               rst_n,
  input  logic               src_we,
  input  logic [IDX_W-1:0]   src_idx,
  input  logic               div3_sw,
  input  logic               div_sw,
  input  logic [2:0]         div_sel,
  input  logic               gate_en,
  output logic               clk_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [IDX_W-1:0]   src_idx_o
);
  logic   clk_src, clk_div, wrap;
  ratio_t req_ratio;

  assign req_ratio = pick_ratio(div3_sw, div_sw, div_sel);

  ccd_src_sel #(.NSEC(NSEC), .HAS_MUX(HAS_MUX)) u_src (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n),
    .src_we  (src_we),
    .src_idx (src_idx),
    .clk_pri (clk_pri),
    .clk_sec (clk_sec),
    .clk_src (clk_src),
    .idx_o   (src_idx_o)
  );

  ccd_divider u_div (
    .clk_src   (clk_src),
    .rst_n     (rst_n),
    .req_ratio (req_ratio),
    .clk_div   (clk_div),
    .act_ratio (ratio_o),
    .wrap      (wrap)
  );

  ccd_gate #(.HAS_GATE(HAS_GATE)) u_gate (
    .clk_in  (clk_div),
    .en      (gate_en),
    .clk_out (clk_o)
  );
endmodule

// File: rtl/ccd_chk.sv
`timescale 1ns/1ps
module ccd_chk #(
  parameter int IDX_W   = 4,
  parameter bit HAS_MUX = 1'b1
) (
  input logic             clk_src,
  input logic             cfg_clk,
  input logic             rst_n,
  input logic             wrap,
  input logic [3:0]       req_ratio,
  input logic             div3_sw,
  input logic             div_sw,
  input logic             src_we,
  input logic [IDX_W-1:0] src_idx,
  input logic [3:0]       ratio_o,
  input logic [IDX_W-1:0] src_idx_o
);
  p_ratio_legal_r1: assert property (@(posedge clk_src) disable iff (!rst_n)
    ratio_o inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12});

  p_div3_wins_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
    (wrap && div3_sw) |=> (ratio_o == 4'd3));

  p_bypass_one_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
    (wrap && !div3_sw && !div_sw) |=> (ratio_o == 4'd1));

  p_load_at_end_r10: assert property (@(posedge clk_src) disable iff (!rst_n)
    wrap |=> (ratio_o == $past(req_ratio)));

  p_hold_mid_r10: assert property (@(posedge clk_src) disable iff (!rst_n)
    !wrap |=> $stable(ratio_o));

  p_index_set_r5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (HAS_MUX && src_we && (src_idx != '0)) |=> (src_idx_o == $past(src_idx)));

  p_index_zero_r5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (src_we && (src_idx == '0)) |=> (src_idx_o == '0));
endmodule

bind composite_clk_div ccd_chk #(.IDX_W(IDX_W), .HAS_MUX(HAS_MUX)) u_chk (
  .clk_src   (clk_src),
  .cfg_clk   (cfg_clk),
  .rst_n     (rst_n),
  .wrap      (wrap),
  .req_ratio (req_ratio),
  .div3_sw   (div3_sw),
  .div_sw    (div_sw),
  .src_we    (src_we),
  .src_idx   (src_idx),
  .ratio_o   (ratio_o),
  .src_idx_o (src_idx_o)
);

// File: tb/composite_clk_div_tb.sv
`timescale 1ns/1ps
module composite_clk_div_tb;
  localparam int NSEC = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [NSEC-1:0] clk_sec;
  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    logic c = 1'b0;
    initial begin
      #0.25;
      forever #(5.0 + i) c = ~c;
    end
    assign clk_sec[i] = c;
  end

  logic       rst_n = 1'b0, src_we = 1'b0, div3_sw = 1'b0, div_sw = 1'b0, gate_en = 1'b1;
  logic [3:0] src_idx = '0;
  logic [2:0] div_sel = '0;
  logic       clk_o, clk_o_min;
  logic [3:0] ratio_o, ratio_min, idx_o, idx_min;

  composite_clk_div #(.NSEC(NSEC)) u_dut (
    .clk_pri(clk), .clk_sec(clk_sec), .cfg_clk(clk), .rst_n(rst_n),
    .src_we(src_we), .src_idx(src_idx), .div3_sw(div3_sw), .div_sw(div_sw),
    .div_sel(div_sel), .gate_en(gate_en), .clk_o(clk_o), .ratio_o(ratio_o),
    .src_idx_o(idx_o));

  composite_clk_div #(.NSEC(NSEC), .HAS_MUX(1'b0), .HAS_GATE(1'b0)) u_min (
    .clk_pri(clk), .clk_sec(clk_sec), .cfg_clk(clk), .rst_n(rst_n),
    .src_we(src_we), .src_idx(src_idx), .div3_sw(div3_sw), .div_sw(div_sw),
    .div_sel(div_sel), .gate_en(gate_en), .clk_o(clk_o_min), .ratio_o(ratio_min),
    .src_idx_o(idx_min));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.05) && (b - a < 0.05);
  endfunction

  function automatic int model_ratio(input bit d3, input bit dsw, input int code);
    int tbl[6] = '{1, 2, 4, 6, 8, 12};
    if (d3) return 3;
    if (!dsw) return 1;
    return (code < 6) ? tbl[code] : 1;
  endfunction

  function automatic real src_per(input int idx);
    return (idx == 0) ? 8.0 : 2.0 * (5.0 + real'(idx - 1));
  endfunction

  typedef struct { int ratio; int idx; real per; real hi; string req; } exp_t;
  exp_t sb[$];
  int   cur_idx = 0;

  // driver: program controls, push expectation, wait for the monitor
  task automatic apply(input int idx, input bit d3, input bit dsw, input int code, input string req);
    exp_t e;
    @(negedge clk);
    div3_sw = d3; div_sw = dsw; div_sel = 3'(code);
    if (idx != cur_idx) begin
      src_we = 1'b1; src_idx = 4'(idx);
      @(negedge clk);
      src_we = 1'b0;
      cur_idx = idx;
    end
    e.ratio = model_ratio(d3, dsw, code);
    e.idx   = idx;
    e.per   = real'(e.ratio) * src_per(idx);
    e.hi    = (e.ratio == 3) ? 1.5 * src_per(idx) : e.per / 2.0;
    e.req   = req;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  // monitor: settle, then compare status and measured waveform
  initial begin
    forever begin
      exp_t e;
      realtime t0, t1, t2;
      wait (sb.size() > 0);
      e = sb[0];
      repeat (3) @(posedge clk_o);
      #1;
      chk(ratio_o == 4'(e.ratio), e.req, "ratio_o", real'(ratio_o), real'(e.ratio));
      chk(idx_o == 4'(e.idx), "R5", "src_idx_o", real'(idx_o), real'(e.idx));
      @(posedge clk_o); t0 = $realtime;
      @(negedge clk_o); t1 = $realtime;
      @(posedge clk_o); t2 = $realtime;
      chk(near(t2 - t0, e.per), "R4", "period", t2 - t0, e.per);
      chk(near(t1 - t0, e.hi), "R6", "high time", t1 - t0, e.hi);
      void'(sb.pop_front());
    end
  end

  int min_edges = 0;
  always @(posedge clk_o_min) min_edges++;

  initial begin
    realtime t0, t1;
    bit stayed_low;
    #10;
    chk(ratio_o == 4'd1, "R9", "ratio in reset", real'(ratio_o), 1.0);
    chk(idx_o == 4'd0, "R9", "index in reset", real'(idx_o), 0.0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    for (int c = 0; c < 8; c++) apply(0, 1'b0, 1'b1, c, "R1");
    apply(0, 1'b1, 1'b1, 5, "R2");
    apply(0, 1'b1, 1'b0, 2, "R2");
    apply(0, 1'b0, 1'b0, 5, "R3");
    apply(0, 1'b0, 1'b0, 4, "R3");
    apply(1, 1'b0, 1'b1, 2, "R4");
    apply(8, 1'b0, 1'b1, 3, "R4");
    apply(3, 1'b1, 1'b0, 0, "R6");
    apply(5, 1'b0, 1'b0, 0, "R6");

    // R8: minimal variant ignores the index write and runs on the primary clock
    chk(idx_min == 4'd0, "R8", "index without mux", real'(idx_min), 0.0);
    chk(ratio_min == 4'd1, "R8", "ratio without mux", real'(ratio_min), 1.0);

    apply(0, 1'b0, 1'b1, 2, "R5");

    // R7: gate off holds the output low, gate-less variant keeps running
    @(negedge clk); gate_en = 1'b0;
    wait (clk_o == 1'b0);
    #1;
    min_edges  = 0;
    stayed_low = 1'b1;
    for (int t = 0; t < 300; t++) begin
      #1;
      if (clk_o) stayed_low = 1'b0;
    end
    chk(stayed_low, "R7", "output low with gate off", real'(clk_o), 0.0);
    chk(min_edges > 5, "R8", "gate-less edges", real'(min_edges), 6.0);
    @(negedge clk); gate_en = 1'b1;
    apply(0, 1'b0, 1'b1, 3, "R7");

    // R10: ratio 12 period completes before a change to ratio 2 applies
    apply(0, 1'b0, 1'b1, 5, "R10");
    @(posedge clk_o); t0 = $realtime;
    @(negedge clk); @(negedge clk);
    div_sel = 3'd1;
    repeat (3) @(negedge clk);
    chk(ratio_o == 4'd12, "R10", "ratio held mid-period", real'(ratio_o), 12.0);
    @(posedge clk_o); t1 = $realtime;
    chk(near(t1 - t0, 96.0), "R10", "old period completes", t1 - t0, 96.0);
    @(negedge clk);
    chk(ratio_o == 4'd2, "R10", "new ratio after boundary", real'(ratio_o), 2.0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule